// File: doc/BRIEF.md
# Channel Address/Count Register File with Save-Restore Access

This block holds the per-channel transfer registers of a four-channel AT-style DMA controller. Each channel has a base address, a current address, a base byte count and a current byte count, all 16 bits wide. Software reaches them through an 8-bit I/O port, one byte at a time. A shared byte-pointer flip-flop chooses the low or the high byte of each access.

In standard mode, software loads the base registers, which it cannot read back. Reads return the live current values. For suspend and resume, firmware sets one enable bit of a configuration byte, which selects the alternate mode. In that mode the roles are swapped. A read returns the saved base value, and a write restores the current value without disturbing the base. Firmware can therefore capture and rebuild the whole channel state. The block does not hold transfers off while in alternate mode, so software masks the channels before it uses the mode.

A step input stands in for transfer activity. On the selected channel it advances the current address and counts down the current count, so the current values move away from the base values.

Top module: `dma_altreg_file`

## Requirements
- R1: After reset every base and current register of every channel is zero, and the byte pointer selects the low byte.
- R2: Alternate mode is active exactly when bit 5 of `cfg_byte` is 1. The other bits of `cfg_byte` have no effect.
- R3: I/O offset 2n addresses the address registers of channel n, and offset 2n+1 addresses its byte-count registers (offsets 0 to 7 for channels 0 to 3).
- R4: In standard mode a write stores the byte into the selected byte of both the base and the current register of the addressed pair.
- R5: In standard mode a read returns the selected byte of the current register of the addressed pair.
- R6: In alternate mode a write stores the byte into the current register only, and the base register keeps its value.
- R7: In alternate mode a read returns the selected byte of the base register of the addressed pair.
- R8: The byte pointer selects the low byte (bits 7:0) when 0 and the high byte (bits 15:8) when 1. It toggles after every read or write cycle, in either mode.
- R9: A `ptr_clr` pulse returns the byte pointer to the low byte on the next cycle, and it overrides a toggle from an access in the same cycle.
- R10: A `step_en` pulse adds 1 to the current address and subtracts 1 from the current count of channel `step_chan`. Both wrap modulo 2^16, and the base registers are unchanged.
- R11: When a write and a step hit the same register in the same cycle, the write result is kept and the step is dropped for that register only.
- R12: `io_rdata` shows the read byte in the same cycle as `io_rd` and is zero whenever `io_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte | input | 8 | Configuration byte; bit 5 enables alternate mode |
| io_addr | input | 3 | Register offset within the block |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, combinational |
| ptr_clr | input | 1 | Clears the byte pointer |
| step_en | input | 1 | Transfer step stand-in |
| step_chan | input | 2 | Channel that the step acts on |

## Verification
Directed sequences first show the difference between the two modes. Base and current values are forced apart with steps, then read in each mode, so a swapped or missing mode steer gives a wrong byte. Count wrap from zero, address wrap from all ones, and a write landing on the same register as a step pin down the update order. The configuration byte is driven with its other bits set and clear, which shows that only the enable bit matters. A seeded random mix of reads, writes, steps, pointer clears and mode flips on all offsets then tests the byte-pointer sequence and the per-channel decoding against a bench model.

// File: rtl/dma_alt_pkg.sv
package dma_alt_pkg;

    localparam int REG_W  = 16;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [REG_W-1:0] base_addr;
        logic [REG_W-1:0] cur_addr;
        logic [REG_W-1:0] base_cnt;
        logic [REG_W-1:0] cur_cnt;
    } chan_regs_t;

    // Replace one byte of a register word; hi selects bits 15:8
    function automatic logic [REG_W-1:0] put_byte(
        input logic [REG_W-1:0]  word,
        input logic              hi,
        input logic [BYTE_W-1:0] b
    );
        logic [REG_W-1:0] r;
        r = word;
        if (hi) r[REG_W-1:BYTE_W] = b;
        else    r[BYTE_W-1:0]     = b;
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] get_byte(
        input logic [REG_W-1:0] word,
        input logic             hi
    );
        return hi ? word[REG_W-1:BYTE_W] : word[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic access,
    input  logic clr,
    output logic hi_q
);

    logic hi_d;

    always_comb begin
        hi_d = hi_q;
        if (clr)         hi_d = 1'b0;
        else if (access) hi_d = ~hi_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hi_q <= 1'b0;
        else        hi_q <= hi_d;
    end

    assert_ptr_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        access && !clr |=> hi_q != $past(hi_q));

    assert_ptr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hi_q);

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !access && !clr |=> $stable(hi_q));

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_alt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel_addr,
    input  logic              sel_cnt,
    input  logic              alt,
    input  logic              hi,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              step,
    output chan_regs_t        regs_q
);

    chan_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        // Transfer activity first; a write to the same register replaces it
        if (step) begin
            regs_d.cur_addr = regs_q.cur_addr + 1'b1;
            regs_d.cur_cnt  = regs_q.cur_cnt - 1'b1;
        end
        if (wr && sel_addr) begin
            regs_d.cur_addr = put_byte(regs_q.cur_addr, hi, wdata);
            if (!alt) regs_d.base_addr = put_byte(regs_q.base_addr, hi, wdata);
        end
        if (wr && sel_cnt) begin
            regs_d.cur_cnt = put_byte(regs_q.cur_cnt, hi, wdata);
            if (!alt) regs_d.base_cnt = put_byte(regs_q.base_cnt, hi, wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assert_alt_keeps_base_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && alt && sel_addr |=> $stable(regs_q.base_addr));

    assert_alt_keeps_base_cnt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr && alt && sel_cnt |=> $stable(regs_q.base_cnt));

    assert_std_low_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !alt && sel_addr && !hi |=> regs_q.base_addr[7:0] == $past(wdata)
                                       && regs_q.cur_addr[7:0]  == $past(wdata));

    assert_step_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step && !(wr && sel_addr) |=> regs_q.cur_addr == $past(regs_q.cur_addr) + 16'd1);

    assert_step_cnt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        step && !(wr && sel_cnt) |=> regs_q.cur_cnt == $past(regs_q.cur_cnt) - 16'd1);

    assert_step_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        step && wr && sel_cnt && hi |=> regs_q.cur_cnt[15:8] == $past(wdata));

    assert_base_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(regs_q.base_addr) && $stable(regs_q.base_cnt));

endmodule

// File: rtl/dma_read_mux.sv
module dma_read_mux
    import dma_alt_pkg::*;
#(
    parameter int CHANNELS = 4,
    localparam int AW = $clog2(2 * CHANNELS)
) (
    input  chan_regs_t [CHANNELS-1:0] regs,
    input  logic [AW-1:0]             addr,
    input  logic                      rd,
    input  logic                      alt,
    input  logic                      hi,
    output logic [BYTE_W-1:0]         rdata
);

    logic [REG_W-1:0] word;

    always_comb begin
        word = '0;
        for (int c = 0; c < CHANNELS; c++) begin
            if (addr == AW'(2 * c)) word = alt ? regs[c].base_addr : regs[c].cur_addr;
            if (addr == AW'(2 * c + 1)) word = alt ? regs[c].base_cnt : regs[c].cur_cnt;
        end
        rdata = rd ? get_byte(word, hi) : '0;
    end

endmodule

// File: rtl/dma_altreg_file.sv
module dma_altreg_file
    import dma_alt_pkg::*;
#(
    parameter int CHANNELS = 4,
    parameter int CFG_W    = 8,
    parameter int ALT_BIT  = 5,
    localparam int AW = $clog2(2 * CHANNELS),
    localparam int CW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_byte,
    input  logic [AW-1:0]     io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [BYTE_W-1:0] io_wdata,
    output logic [BYTE_W-1:0] io_rdata,
    input  logic              ptr_clr,
    input  logic              step_en,
    input  logic [CW-1:0]     step_chan
);

    logic                      alt_mode;
    logic                      in_range;
    logic                      hi_q;
    chan_regs_t [CHANNELS-1:0] regs;

    always_comb begin
        alt_mode = cfg_byte[ALT_BIT];
        in_range = (int'(io_addr) < 2 * CHANNELS);
    end

    dma_byte_ptr u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .access ((io_rd || io_wr) && in_range),
        .clr    (ptr_clr),
        .hi_q   (hi_q)
    );

    for (genvar g = 0; g < CHANNELS; g++) begin : g_chan
        dma_chan_regs u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr       (io_wr),
            .sel_addr (io_addr == AW'(2 * g)),
            .sel_cnt  (io_addr == AW'(2 * g + 1)),
            .alt      (alt_mode),
            .hi       (hi_q),
            .wdata    (io_wdata),
            .step     (step_en && (step_chan == CW'(g))),
            .regs_q   (regs[g])
        );
    end

    dma_read_mux #(.CHANNELS(CHANNELS)) u_mux (
        .regs  (regs),
        .addr  (io_addr),
        .rd    (io_rd),
        .alt   (alt_mode),
        .hi    (hi_q),
        .rdata (io_rdata)
    );

    assert_idle_rdata_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> io_rdata == '0);

endmodule

// File: tb/dma_altreg_file_test.sv
module dma_altreg_file_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] cfg_byte;
    logic [2:0] io_addr;
    logic       io_rd, io_wr;
    logic [7:0] io_wdata;
    logic [7:0] io_rdata;
    logic       ptr_clr, step_en;
    logic [1:0] step_chan;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_ba[4], m_ca[4], m_bc[4], m_cc[4];
    logic        m_ptr;

    always #5 clk = ~clk;

    dma_altreg_file uut (
        .clk(clk), .rst_n(rst_n), .cfg_byte(cfg_byte), .io_addr(io_addr),
        .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ptr_clr(ptr_clr), .step_en(step_en), .step_chan(step_chan)
    );

    function automatic logic [7:0] mk_cfg(bit alt, logic [7:0] noise);
        return (noise & 8'hDF) | (alt ? 8'h20 : 8'h00);
    endfunction

    function automatic logic [7:0] exp_rd(int a, bit alt);
        logic [15:0] w;
        int ch = a / 2;
        if (a % 2 == 0) w = alt ? m_ba[ch] : m_ca[ch];
        else            w = alt ? m_bc[ch] : m_cc[ch];
        return m_ptr ? w[15:8] : w[7:0];
    endfunction

    function automatic logic [15:0] put(logic [15:0] w, logic hi, logic [7:0] b);
        if (hi) w[15:8] = b; else w[7:0] = b;
        return w;
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string rq);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
        end
    endtask

    // One bus cycle with any mix of strobes; reads are checked before the edge
    task automatic cyc(bit wr, bit rd, int a, logic [7:0] d, bit alt,
                       bit clr, bit st, int sc, string rq);
        int ch;
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = 3'(a); io_wdata = d;
        cfg_byte = mk_cfg(alt, 8'($urandom));
        ptr_clr = clr; step_en = st; step_chan = 2'(sc);
        #2;
        if (rd) check(io_rdata, exp_rd(a, alt), rq);
        else    check(io_rdata, 8'h00, "R12");
        @(posedge clk);
        #1;
        ch = a / 2;
        if (st) begin
            m_ca[sc] = m_ca[sc] + 16'd1;
            m_cc[sc] = m_cc[sc] - 16'd1;
        end
        if (wr) begin
            if (a % 2 == 0) begin
                m_ca[ch] = put(m_ca[ch], m_ptr, d);
                if (!alt) m_ba[ch] = put(m_ba[ch], m_ptr, d);
            end else begin
                m_cc[ch] = put(m_cc[ch], m_ptr, d);
                if (!alt) m_bc[ch] = put(m_bc[ch], m_ptr, d);
            end
        end
        if (clr) m_ptr = 1'b0;
        else if (wr || rd) m_ptr = ~m_ptr;
        io_wr = 0; io_rd = 0; ptr_clr = 0; step_en = 0;
    endtask

    task automatic wr16(int a, logic [15:0] v, bit alt, string rq);
        cyc(1, 0, a, v[7:0], alt, 0, 0, 0, rq);
        cyc(1, 0, a, v[15:8], alt, 0, 0, 0, rq);
    endtask

    task automatic rd16(int a, bit alt, string rq);
        cyc(0, 1, a, 8'h00, alt, 0, 0, 0, rq);
        cyc(0, 1, a, 8'h00, alt, 0, 0, 0, rq);
    endtask

    task automatic clr_ptr();
        cyc(0, 0, 0, 8'h00, 0, 1, 0, 0, "R9");
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 4; i++) begin
            m_ba[i] = 0; m_ca[i] = 0; m_bc[i] = 0; m_cc[i] = 0;
        end
        m_ptr = 0;
        rst_n = 0; io_rd = 0; io_wr = 0; io_addr = 0; io_wdata = 0;
        cfg_byte = 0; ptr_clr = 0; step_en = 0; step_chan = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: all registers zero in both modes, pointer on low byte
        for (int a = 0; a < 8; a++) begin
            rd16(a, 0, "R1");
            rd16(a, 1, "R1");
        end

        // R3 R4 R5: standard writes to distinct values on every offset
        for (int a = 0; a < 8; a++) wr16(a, 16'h1100 * 16'(a + 1) + 16'h0034 + 16'(a), 0, "R4");
        for (int a = 0; a < 8; a++) rd16(a, 0, "R3");
        for (int a = 0; a < 8; a++) rd16(a, 1, "R4");

        // R10: steps split current from base; base reads unchanged
        for (int c = 0; c < 4; c++) cyc(0, 0, 0, 8'h00, 0, 0, 1, c, "R10");
        cyc(0, 0, 0, 8'h00, 0, 0, 1, 2, "R10");
        for (int a = 0; a < 8; a++) rd16(a, 0, "R5");
        for (int a = 0; a < 8; a++) rd16(a, 1, "R7");

        // R2: noise bits only; cfg drives random other bits each cycle
        rd16(4, 0, "R2");
        rd16(4, 1, "R2");

        // R6: alternate write restores current, base intact
        wr16(2, 16'hBEEF, 1, "R6");
        wr16(7, 16'h0A0B, 1, "R6");
        rd16(2, 0, "R6");
        rd16(2, 1, "R6");
        rd16(7, 0, "R6");
        rd16(7, 1, "R6");

        // R8 R9: pointer odd state, then clear overriding a read toggle
        cyc(0, 1, 1, 8'h00, 0, 0, 0, 0, "R8");
        cyc(0, 1, 1, 8'h00, 0, 1, 0, 0, "R9");
        rd16(1, 0, "R9");

        // R10 wrap: count 0 -> FFFF, address FFFF -> 0
        clr_ptr();
        wr16(5, 16'h0000, 0, "R10");
        wr16(4, 16'hFFFF, 1, "R10");
        cyc(0, 0, 0, 8'h00, 0, 0, 1, 2, "R10");
        rd16(5, 0, "R10");
        rd16(4, 0, "R10");

        // R11: write and step on the same register in one cycle
        clr_ptr();
        cyc(1, 0, 6, 8'h5A, 0, 0, 1, 3, "R11");
        rd16(6, 0, "R11");
        rd16(7, 0, "R11");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int op = int'($urandom_range(0, 9));
            int a  = int'($urandom_range(0, 7));
            bit al = 1'($urandom);
            logic [7:0] d = 8'($urandom);
            if (op < 4)       cyc(0, 1, a, d, al, 0, 0, 0, "R8");
            else if (op < 7)  cyc(1, 0, a, d, al, 0, 0, 0, al ? "R6" : "R4");
            else if (op < 9)  cyc(0, 0, a, d, al, 0, 1, int'($urandom_range(0, 3)), "R10");
            else              cyc(0, 0, a, d, al, 1, 0, 0, "R9");
        end
        for (int a = 0; a < 8; a++) begin
            rd16(a, 0, "R5");
            rd16(a, 1, "R7");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule